// File: doc/BRIEF.md
# Smart Card Initial Character Detector

After a card reset the receiver arms this block. It then watches the card I/O line, which is already synchronized and idles high, for the opening character. It sorts that character into one of two conventions:

- **Direct convention:** a high level is a 1 and the least significant bit goes first.
- **Inverse convention:** a low level is a 1 and the most significant bit goes first.

From the time between the first two falling edges, the block derives the bit period (ETU) in system clock cycles. It then samples the remaining bits of the character in the middle of each bit and reports the decoded byte.

Two things are held for downstream receivers:

- The convention flag stays latched until the next reset, so a receiver can apply bit inversion and reversal to later characters.
- The measured ETU, or a fixed fallback when measurement is switched off, serves as the receiver's timing reference.

Timeouts and malformed characters end in an error flag instead of a valid result.

Top module: `sc_ts_detect`

## Requirements
- R1: During and right after reset, valid_o, err_o and inverse_o are 0, byte_o is 0x00, and etu_o equals DEF_ETU.
- R2: The line sequence, one ETU per element, low, high, high, low, high, high, high, low, low, high sets valid_o with inverse_o = 0 and byte_o = 0x3B.
- R3: The line sequence low, high, high, low, low, low, low, low, low, high sets valid_o with inverse_o = 1 and byte_o = 0x3F.
- R4: With meas_en_i = 1, etu_o equals the clock count between the first and second falling edges after arming, divided by three and rounded down.
- R5: With meas_en_i = 0, etu_o equals DEF_ETU, and bits are sampled on that period.
- R6: Bits 4 to 9 are sampled at the middle of each bit, measured from the first falling edge. If they match neither of the two sequences in R2 and R3, err_o is set and valid_o stays 0.
- R7: If no falling edge arrives within timeout_i cycles of arming, err_o is set.
- R8: If the second falling edge does not arrive within 2^CNT_W - 1 cycles of the first, err_o is set.
- R9: With meas_en_i = 1, a measured ETU below MIN_ETU = (2*CNT_W+8)/3 + 1 sets err_o.
- R10: inverse_o changes only in the cycle valid_o rises. Errors and re-arming leave it unchanged.
- R11: valid_o and err_o are never both 1. The cycle after arm_i, both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_i | input | 1 | One-cycle strobe that starts a detection |
| line_i | input | 1 | Synchronized card I/O level |
| meas_en_i | input | 1 | 1: use the measured ETU; 0: use DEF_ETU |
| timeout_i | input | CNT_W | Maximum cycles to wait for the start edge |
| valid_o | output | 1 | A character was recognized |
| err_o | output | 1 | Detection failed |
| inverse_o | output | 1 | Latched convention, 1 = inverse |
| etu_o | output | CNT_W | Bit period in clock cycles |
| byte_o | output | 8 | Decoded value of the character |

## Verification
The bench builds the block with CNT_W = 12 and DEF_ETU = 372. This small counter width puts the edge-interval overflow limit (4095 cycles) and the minimum ETU of 11 cycles within a short run.

- Both conventions are swept over every ETU from 11 to 40 cycles.
- All 64 combinations of the six sampled bits are swept at one ETU.
- The 372-cycle fallback, a short start timeout, a missing second edge and a too-short ETU are each run once.

The convention flag is tracked across all of these runs.

// File: rtl/sc_ts_detect.sv
module sc_ts_detect #(
  parameter int CNT_W   = 16,
  parameter int DEF_ETU = 372
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_i,
  input  logic             line_i,
  input  logic             meas_en_i,
  input  logic [CNT_W-1:0] timeout_i,
  output logic             valid_o,
  output logic             err_o,
  output logic             inverse_o,
  output logic [CNT_W-1:0] etu_o,
  output logic [7:0]       byte_o
);
  localparam int TW      = CNT_W + 3;
  localparam int SW      = $clog2(CNT_W + 1);
  localparam int MIN_ETU = (2 * CNT_W + 8) / 3 + 1;

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_MEAS, S_DIV, S_SETUP, S_SAMP} st_t;

  st_t              st;
  logic             line_q;
  logic [TW-1:0]    cnt, target;
  logic [CNT_W-1:0] dvd, quo, etu_sel;
  logic [1:0]       rem;
  logic [SW-1:0]    step;
  logic [5:0]       smp;
  logic [2:0]       nbit;

  wire       fall  = line_q & ~line_i;
  wire [2:0] r3    = {rem, dvd[CNT_W-1]};
  wire       ge3   = r3 >= 3'd3;
  wire [5:0] tail  = {line_i, smp[5:1]};
  wire       is_dir = tail == 6'b100111;
  wire       is_inv = tail == 6'b100000;
  wire [9:0] word  = {tail, 4'b0110};

  assign etu_sel = meas_en_i ? quo : CNT_W'(DEF_ETU);

  function automatic logic [7:0] rev_not(input logic [7:0] v);
    for (int j = 0; j < 8; j++) rev_not[7-j] = ~v[j];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; line_q <= 1'b1; cnt <= '0; target <= '0;
      dvd <= '0; quo <= '0; rem <= '0; step <= '0; smp <= '0; nbit <= '0;
      valid_o <= 1'b0; err_o <= 1'b0; inverse_o <= 1'b0;
      etu_o <= CNT_W'(DEF_ETU); byte_o <= 8'h00;
    end else begin
      line_q <= line_i;
      if (arm_i) begin
        st <= S_WAIT; cnt <= '0; valid_o <= 1'b0; err_o <= 1'b0; byte_o <= 8'h00;
      end else begin
        case (st)
          S_WAIT:
            if (fall) begin
              cnt <= TW'(1); st <= S_MEAS;
            end else if (cnt == TW'(timeout_i)) begin
              err_o <= 1'b1; st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_MEAS:
            if (fall) begin
              dvd <= cnt[CNT_W-1:0]; rem <= '0; quo <= '0; step <= '0;
              cnt <= cnt + 1'b1; st <= S_DIV;
            end else if (cnt == TW'({CNT_W{1'b1}})) begin
              err_o <= 1'b1; st <= S_IDLE;
            end else cnt <= cnt + 1'b1;
          S_DIV: begin
            cnt  <= cnt + 1'b1;
            rem  <= ge3 ? 2'(r3 - 3'd3) : r3[1:0];
            quo  <= {quo[CNT_W-2:0], ge3};
            dvd  <= dvd << 1;
            step <= step + 1'b1;
            if (step == SW'(CNT_W - 1)) st <= S_SETUP;
          end
          S_SETUP: begin
            cnt <= cnt + 1'b1;
            etu_o <= etu_sel;
            target <= (TW'(etu_sel) << 2) + TW'(etu_sel >> 1);
            nbit <= '0;
            if (meas_en_i && quo < CNT_W'(MIN_ETU)) begin
              err_o <= 1'b1; st <= S_IDLE;
            end else st <= S_SAMP;
          end
          S_SAMP: begin
            cnt <= cnt + 1'b1;
            if (cnt == target) begin
              smp <= tail;
              target <= target + TW'(etu_o);
              nbit <= nbit + 1'b1;
              if (nbit == 3'd5) begin
                st <= S_IDLE;
                if (is_dir || is_inv) begin
                  valid_o <= 1'b1;
                  inverse_o <= is_inv;
                  byte_o <= is_inv ? rev_not(word[8:1]) : word[8:1];
                end else err_o <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  excl_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));
  // R11
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (!valid_o && !err_o));
  // R10
  conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(valid_o) |-> $stable(inverse_o));
  // R2
  direct_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !inverse_o) |-> byte_o == 8'h3B);
  // R3
  inverse_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && inverse_o) |-> byte_o == 8'h3F);
  // R9
  min_etu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && meas_en_i) |-> etu_o >= CNT_W'(MIN_ETU));
endmodule

// File: tb/test_sc_ts_detect.sv
module test_sc_ts_detect;
  localparam int CW  = 12;
  localparam int DEF = 372;
  localparam int MIN = (2 * CW + 8) / 3 + 1;

  logic clk = 0, rst_n = 0, arm = 0, line = 1, meas_en = 1;
  logic [CW-1:0] tmo = CW'(4000);
  logic valid, err, inv;
  logic [CW-1:0] etu;
  logic [7:0] byt;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic exp_inv = 0;

  always #2 clk = ~clk;

  sc_ts_detect #(.CNT_W(CW), .DEF_ETU(DEF)) i_sc_ts_detect (
    .clk(clk), .rst_n(rst_n), .arm_i(arm), .line_i(line), .meas_en_i(meas_en),
    .timeout_i(tmo), .valid_o(valid), .err_o(err), .inverse_o(inv),
    .etu_o(etu), .byte_o(byt));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_arm();
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
    // R11: flags cleared after arm
    chk(!valid && !err, "R11", {valid, err}, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic send(input logic [5:0] tl, input int e);
    logic [9:0] pat;
    pat = {tl, 4'b0110};
    for (int b = 0; b < 10; b++) begin
      line = pat[b];
      repeat (e) @(negedge clk);
    end
    line = 1;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 600 && !valid && !err; k++) @(negedge clk);
  endtask

  task automatic run(input logic [5:0] tl, input int e, input int exp_etu);
    bit good_d, good_i;
    good_d = tl == 6'b100111;
    good_i = tl == 6'b100000;
    do_arm();
    send(tl, e);
    wait_done();
    if (good_d || good_i) begin
      exp_inv = good_i;
      chk(valid && !err, good_i ? "R3" : "R2", {valid, err}, 2);
      chk(byt == (good_i ? 8'h3F : 8'h3B), good_i ? "R3" : "R2", byt, good_i ? 'h3F : 'h3B);
      chk(etu == CW'(exp_etu), meas_en ? "R4" : "R5", etu, exp_etu);
    end else begin
      chk(err && !valid, "R6", {valid, err}, 1);
    end
    chk(inv == exp_inv, "R10", inv, exp_inv);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!valid && !err && !inv, "R1", {valid, err, inv}, 0);
    chk(etu == CW'(DEF) && byt == 0, "R1", etu, DEF);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int e = MIN; e <= 40; e++) begin
      run(6'b100111, e, e);
      run(6'b100000, e, e);
    end
    for (int t = 0; t < 64; t++) run(6'(t), 16, 16);

    meas_en = 0;
    run(6'b100000, DEF, DEF);
    run(6'b100111, DEF, DEF);
    meas_en = 1;

    // R9: ETU below minimum
    run(6'b100000, 20, 20);
    do_arm();
    send(6'b100111, 4);
    wait_done();
    chk(err && !valid, "R9", {valid, err}, 1);
    chk(inv == exp_inv, "R10", inv, exp_inv);

    // R7: start timeout
    tmo = CW'(40);
    @(negedge clk) arm = 1;
    @(negedge clk) arm = 0;
    repeat (38) @(negedge clk);
    chk(!err, "R7", err, 0);
    repeat (6) @(negedge clk);
    chk(err && !valid, "R7", err, 1);
    tmo = CW'(4000);

    // R8: second falling edge never arrives
    do_arm();
    line = 0;
    repeat (8) @(negedge clk);
    line = 1;
    repeat (4000) @(negedge clk);
    chk(!err, "R8", err, 0);
    repeat (200) @(negedge clk);
    chk(err && !valid, "R8", err, 1);
    chk(inv == exp_inv, "R10", inv, exp_inv);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule